// File: doc/BRIEF.md
# Nanosecond Alarm Timer

A bus-attached peripheral that keeps a free-running 64-bit time count in nanoseconds and offers one programmable alarm. The count starts at zero after reset and advances every clock by a fixed number of nanoseconds set by a parameter. Software sees it through a 32-bit register port that decodes a 4 KiB window and gives one level interrupt output.

Reading the lower time word also copies the whole 64-bit count into a hold register, so a later read of the upper word gives a consistent pair. To program the alarm, software writes the upper alarm word first and the lower word second. Writing the lower word commits the full 64-bit alarm. If that alarm is not later than the current count, the interrupt is raised at once and nothing stays armed. Otherwise the alarm is armed and fires when the count reaches it. Two write-only commands drop the interrupt: one leaves the alarm armed and the other also cancels it.

Top module: `ns_alarm_timer`

## Requirements
- R1: Reset clears the time count, both alarm words, the hold register, the armed state and the interrupt. After reset the count grows by NS_PER_CLK in each clock cycle.
- R2: A read at offset 0x000 copies the full count value of the request cycle into the hold register. Its lower 32 bits appear on `bus_rdata` in the next cycle.
- R3: A read at offset 0x004 returns bits 63:32 of the hold register, taken from the most recent 0x000 read and not from the live count. The data appears on `bus_rdata` in the next cycle.
- R4: A write at offset 0x00C stores the upper alarm word only. It leaves the interrupt and the armed state unchanged.
- R5: A write at offset 0x008 stores the lower alarm word and compares {upper word, write data} with the count of the request cycle, as unsigned 64-bit values. If the alarm is less than or equal to the count, `irq` is 1 from the next cycle and the block is disarmed. Otherwise the block becomes armed.
- R6: When the block is armed and the count is greater than or equal to the alarm, `irq` is 1 from the next cycle and the block disarms, so the alarm fires only once.
- R7: A write at offset 0x014 disarms the alarm and drops `irq` in the next cycle. A write at offset 0x010 drops `irq` and keeps the armed state. An alarm that is due in the same cycle as a 0x010 write fires one cycle later.
- R8: `irq` is a level. Once set, it stays 1 until a write at offset 0x010 or 0x014.
- R9: Reads at 0x000 and 0x004 are defined, and so are writes at 0x008, 0x00C, 0x010 and 0x014. Any other access is undefined. An undefined access changes no state, returns 0 on `bus_rdata`, and drives `bus_err` high for exactly the next cycle.
- R10: `bus_rdata` is 0 in every cycle that does not follow a defined read. `bus_err` is 0 in every cycle that does not follow an undefined access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle error for an undefined access |
| irq | output | 1 | Level alarm interrupt |

## Verification
Read data and the error flag are due exactly one cycle after the clock edge that takes the request. An alarm that is already due sets `irq` one cycle after its lower-word write. An alarm set k count steps ahead of the count at that write raises `irq` k cycles after the write edge. The bench drives inputs and samples outputs on the falling edge. It tracks the count with its own step model, so the expected value of each result is known for the exact falling edge at which it is checked. A cycle-by-cycle reference model also compares `irq`, `bus_rdata` and `bus_err` at every falling edge during the random phase.

// File: rtl/nat_pkg.sv
package nat_pkg;

   // Word offsets decoded inside the register window
   localparam logic [4:0] OFS_TIME_LO    = 5'h00;
   localparam logic [4:0] OFS_TIME_HI    = 5'h04;
   localparam logic [4:0] OFS_ALARM_LO   = 5'h08;
   localparam logic [4:0] OFS_ALARM_HI   = 5'h0C;
   localparam logic [4:0] OFS_IRQ_CLR    = 5'h10;
   localparam logic [4:0] OFS_ALARM_STOP = 5'h14;

   // One decoded bus operation, at most one bit set
   typedef struct packed {
      logic rd_time_lo;
      logic rd_time_hi;
      logic wr_alarm_lo;
      logic wr_alarm_hi;
      logic wr_irq_clr;
      logic wr_alarm_stop;
      logic bad;
   } nat_op_t;

endpackage

// File: rtl/nat_counter.sv
module nat_counter #(
   parameter int                 TIME_W = 64,
   parameter logic [TIME_W-1:0]  STEP   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TIME_W-1:0] now
);

   always_ff @(posedge clk) begin
      if (!rst_n) now <= '0;
      else        now <= now + STEP;
   end

   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> now == $past(now) + STEP);

endmodule

// File: rtl/nat_decode.sv
module nat_decode
   import nat_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output nat_op_t           op
);

   localparam int LOW_W = 5;

   logic             upper_zero;
   logic [LOW_W-1:0] low;

   assign upper_zero = (addr >> LOW_W) == '0;
   assign low        = addr[LOW_W-1:0];

   always_comb begin
      op = '0;
      if (sel) begin
         if (upper_zero && !wr && low == OFS_TIME_LO)         op.rd_time_lo    = 1'b1;
         else if (upper_zero && !wr && low == OFS_TIME_HI)    op.rd_time_hi    = 1'b1;
         else if (upper_zero && wr && low == OFS_ALARM_LO)    op.wr_alarm_lo   = 1'b1;
         else if (upper_zero && wr && low == OFS_ALARM_HI)    op.wr_alarm_hi   = 1'b1;
         else if (upper_zero && wr && low == OFS_IRQ_CLR)     op.wr_irq_clr    = 1'b1;
         else if (upper_zero && wr && low == OFS_ALARM_STOP)  op.wr_alarm_stop = 1'b1;
         else                                                 op.bad           = 1'b1;
      end
   end

   always_comb begin
      assert_one_op_R9: assert ($onehot0(op));
   end

endmodule

// File: rtl/nat_alarm.sv
module nat_alarm
   import nat_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int TIME_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now,
   input  nat_op_t           op,
   input  logic [DATA_W-1:0] wdata,
   output logic              irq
);

   logic [DATA_W-1:0] alarm_lo, alarm_hi;
   logic              armed;
   logic [TIME_W-1:0] alarm_full, alarm_cand;
   logic              due, cand_past, any_ctl;

   assign alarm_full = {alarm_hi, alarm_lo};
   assign alarm_cand = {alarm_hi, wdata};
   assign due        = armed && (now >= alarm_full);
   assign cand_past  = alarm_cand <= now;
   assign any_ctl    = op.wr_alarm_lo | op.wr_alarm_stop | op.wr_irq_clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm_lo <= '0;
         alarm_hi <= '0;
         armed    <= 1'b0;
         irq      <= 1'b0;
      end else begin
         if (op.wr_alarm_hi) alarm_hi <= wdata;
         if (op.wr_alarm_lo) begin
            alarm_lo <= wdata;
            if (cand_past) begin
               irq   <= 1'b1;
               armed <= 1'b0;
            end else begin
               armed <= 1'b1;
            end
         end else if (op.wr_alarm_stop) begin
            armed <= 1'b0;
            irq   <= 1'b0;
         end else if (op.wr_irq_clr) begin
            irq   <= 1'b0;
         end else if (due) begin
            armed <= 1'b0;
            irq   <= 1'b1;
         end
      end
   end

   assert_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && now >= alarm_full && !any_ctl) |=> (irq && !armed));

   assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      op.wr_alarm_stop |=> (!irq && !armed));

   assert_clr_keeps_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      op.wr_irq_clr |=> (!irq && armed == $past(armed)));

   assert_hi_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op.wr_alarm_hi |=> ($stable(alarm_lo) && (irq || !$past(irq))));

   assert_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !op.wr_irq_clr && !op.wr_alarm_stop) |=> irq);

endmodule

// File: rtl/ns_alarm_timer.sv
module ns_alarm_timer
   import nat_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          ADDR_W     = 12,
   parameter logic [63:0] NS_PER_CLK = 64'd5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   output logic              irq
);

   localparam int TIME_W = 2 * DATA_W;

   // Elaboration-time parameter checks
   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("ns_alarm_timer: DATA_W must be 32");
      end
      if (ADDR_W < 6 || ADDR_W > 16) begin : g_bad_addr_w
         $error("ns_alarm_timer: ADDR_W must lie in 6..16");
      end
      if (NS_PER_CLK == 64'd0) begin : g_bad_step
         $error("ns_alarm_timer: NS_PER_CLK must be nonzero");
      end
   endgenerate

   logic [TIME_W-1:0] now;
   logic [TIME_W-1:0] hold;
   nat_op_t           op;

   nat_counter #(.TIME_W(TIME_W), .STEP(TIME_W'(NS_PER_CLK))) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .now   (now)
   );

   nat_decode #(.ADDR_W(ADDR_W)) u_decode (
      .sel  (bus_sel),
      .wr   (bus_wr),
      .addr (bus_addr),
      .op   (op)
   );

   nat_alarm #(.DATA_W(DATA_W)) u_alarm (
      .clk   (clk),
      .rst_n (rst_n),
      .now   (now),
      .op    (op),
      .wdata (bus_wdata),
      .irq   (irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold      <= '0;
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_err <= op.bad;
         if (op.rd_time_lo) begin
            hold      <= now;
            bus_rdata <= now[DATA_W-1:0];
         end else if (op.rd_time_hi) begin
            bus_rdata <= hold[TIME_W-1:DATA_W];
         end else begin
            bus_rdata <= '0;
         end
      end
   end

   assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      op.bad |=> (bus_err && bus_rdata == '0));

   assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !op.bad |=> !bus_err);

   assert_lo_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      op.rd_time_lo |=> bus_rdata == $past(now[DATA_W-1:0]));

   assert_hi_from_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      op.rd_time_hi |=> (bus_rdata == $past(hold[TIME_W-1:DATA_W]) && $stable(hold)));

endmodule

// File: tb/ns_alarm_timer_bench.sv
module ns_alarm_timer_bench;

   localparam logic [63:0] NS = 64'd1_000_000_007;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic        irq;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   bit model_on = 1'b0;

   always #2.5 clk = ~clk;

   ns_alarm_timer #(.DATA_W(32), .ADDR_W(12), .NS_PER_CLK(NS)) u_ns_alarm_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_err   (bus_err),
      .irq       (irq)
   );

   // Reference model built from the requirements
   logic [63:0] m_now, m_hold, m_cand;
   logic [31:0] m_ahi, m_alo, m_rdata;
   logic        m_arm, m_irq, m_err;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_now <= '0; m_hold <= '0; m_ahi <= '0; m_alo <= '0;
         m_arm <= 1'b0; m_irq <= 1'b0; m_rdata <= '0; m_err <= 1'b0;
      end else begin
         m_now   <= m_now + NS;
         m_rdata <= '0;
         m_err   <= 1'b0;
         m_cand  = {m_ahi, bus_wdata};
         if (bus_sel && !bus_wr && bus_addr == 12'h000) begin
            m_hold <= m_now; m_rdata <= m_now[31:0];
         end else if (bus_sel && !bus_wr && bus_addr == 12'h004) begin
            m_rdata <= m_hold[63:32];
         end else if (bus_sel && bus_wr && bus_addr == 12'h00C) begin
            m_ahi <= bus_wdata;
         end
         if (bus_sel && bus_wr && bus_addr == 12'h008) begin
            m_alo <= bus_wdata;
            if (m_cand <= m_now) begin m_irq <= 1'b1; m_arm <= 1'b0; end
            else m_arm <= 1'b1;
         end else if (bus_sel && bus_wr && bus_addr == 12'h014) begin
            m_arm <= 1'b0; m_irq <= 1'b0;
         end else if (bus_sel && bus_wr && bus_addr == 12'h010) begin
            m_irq <= 1'b0;
         end else if (m_arm && m_now >= {m_ahi, m_alo}) begin
            m_arm <= 1'b0; m_irq <= 1'b1;
         end
         if (bus_sel && !((!bus_wr && (bus_addr == 12'h000 || bus_addr == 12'h004)) ||
                          (bus_wr && (bus_addr == 12'h008 || bus_addr == 12'h00C ||
                                      bus_addr == 12'h010 || bus_addr == 12'h014))))
            m_err <= 1'b1;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison in the random phase
   always @(negedge clk) begin
      if (model_on) begin
         check("R8 irq vs model", irq, m_irq);
         check("R2 rdata vs model", bus_rdata, m_rdata);
         check("R9 err vs model", bus_err, m_err);
      end
   end

   // Called at a falling edge; returns at the falling edge after the access edge
   task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Alarm k steps beyond the count at the lower-word write; check irq timing
   task automatic alarm_at(input int k, input string req);
      logic [63:0] tgt;
      int first;
      tgt = m_now + NS + NS * 64'(longint'(k));
      access(1'b1, 12'h00C, tgt[63:32]);
      access(1'b1, 12'h008, tgt[31:0]);
      first = (k > 0) ? k : 0;
      for (int j = 0; j <= first + 2; j++) begin
         check(req, irq, (j >= first) ? 1'b1 : 1'b0);
         if (j < first + 2) @(negedge clk);
      end
   endtask

   initial begin
      logic [63:0] exp_a, exp_b;
      int dummy;
      dummy = $urandom(32'h5EED_0042);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 / R1: reset state
      check("R10 rdata after reset", bus_rdata, 32'h0);
      check("R10 err after reset", bus_err, 1'b0);
      check("R1 irq after reset", irq, 1'b0);

      // R2 / R3: split read with a frozen upper word
      exp_a = m_now;
      access(1'b0, 12'h000, 32'h0);
      check("R2 time low", bus_rdata, exp_a[31:0]);
      check("R1 count step", bus_rdata, NS[31:0]);
      idle(8);
      access(1'b0, 12'h004, 32'h0);
      check("R3 high from hold not live", bus_rdata, exp_a[63:32]);
      exp_b = m_now;
      access(1'b0, 12'h000, 32'h0);
      check("R2 time low again", bus_rdata, exp_b[31:0]);
      idle(3);
      access(1'b0, 12'h004, 32'h0);
      check("R3 high of second capture", bus_rdata, exp_b[63:32]);

      // R4: upper word write alone does nothing visible
      access(1'b1, 12'h00C, 32'hFFFF_FFFF);
      check("R4 no irq from upper write", irq, 1'b0);
      access(1'b1, 12'h008, 32'h0);
      idle(10);
      check("R5 far future alarm stays quiet", irq, 1'b0);
      access(1'b1, 12'h014, 32'h0);

      // R5: alarm in the past and exactly now
      alarm_at(-3, "R5 past alarm fires at once");
      idle(4);
      check("R8 irq held", irq, 1'b1);
      access(1'b1, 12'h010, 32'h0);
      check("R7 clear drops irq", irq, 1'b0);
      alarm_at(0, "R5 alarm equal to count fires at once");
      access(1'b1, 12'h010, 32'h0);

      // R6: future alarms fire after the expected number of cycles
      alarm_at(1, "R6 alarm one step ahead");
      access(1'b1, 12'h010, 32'h0);
      alarm_at(7, "R6 alarm seven steps ahead");
      access(1'b1, 12'h010, 32'h0);
      idle(5);
      check("R6 fires only once", irq, 1'b0);

      // R7: cancel stops a pending alarm
      exp_a = m_now + NS * 64'd12;
      access(1'b1, 12'h00C, exp_a[63:32]);
      access(1'b1, 12'h008, exp_a[31:0]);
      idle(2);
      access(1'b1, 12'h014, 32'h0);
      idle(20);
      check("R7 cancelled alarm never fires", irq, 1'b0);

      // R7: interrupt clear keeps the alarm armed
      exp_a = m_now + NS * 64'd10;
      access(1'b1, 12'h00C, exp_a[63:32]);
      access(1'b1, 12'h008, exp_a[31:0]);
      access(1'b1, 12'h010, 32'h0);
      idle(12);
      check("R7 armed alarm survives irq clear", irq, 1'b1);
      access(1'b1, 12'h010, 32'h0);

      // R9: undefined accesses
      access(1'b0, 12'h008, 32'h0);
      check("R9 read of write offset data", bus_rdata, 32'h0);
      check("R9 read of write offset err", bus_err, 1'b1);
      @(negedge clk);
      check("R9 err lasts one cycle", bus_err, 1'b0);
      access(1'b1, 12'h000, 32'h1234);
      check("R9 write of read offset err", bus_err, 1'b1);
      access(1'b1, 12'h018, 32'h0);
      check("R9 write past map err", bus_err, 1'b1);
      check("R9 undefined write leaves irq", irq, 1'b0);
      access(1'b0, 12'h002, 32'h0);
      check("R9 unaligned read err", bus_err, 1'b1);
      access(1'b0, 12'h800, 32'h0);
      check("R9 high window read err", bus_err, 1'b1);
      check("R10 rdata zero on error", bus_rdata, 32'h0);

      // Random phase checked against the model every cycle
      model_on = 1'b1;
      for (int it = 0; it < 4000; it++) begin
         int op;
         op = $urandom_range(0, 11);
         case (op)
            0: access(1'b0, 12'h000, 32'h0);
            1: access(1'b0, 12'h004, 32'h0);
            2: access(1'b1, 12'h00C, exp_a[63:32]);
            3, 4: begin
               exp_a = m_now + NS * 64'(longint'($urandom_range(0, 34)) - 64'sd4);
               access(1'b1, 12'h008, exp_a[31:0]);
            end
            5: access(1'b1, 12'h010, 32'h0);
            6: if ($urandom_range(0, 3) == 0) access(1'b1, 12'h014, 32'h0);
               else idle(1);
            7: access($urandom_range(0, 1) == 1, 12'($urandom_range(0, 4095)), $urandom);
            default: idle($urandom_range(1, 6));
         endcase
         if (op != 2 && op != 3 && op != 4) exp_a = m_now + NS * 64'd3;
      end
      idle(2);
      model_on = 1'b0;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule